// File: doc/BRIEF.md
# Reciprocal-Multiply Unsigned Quotient Unit

This unit returns the unsigned quotient of a W-bit dividend by a divisor that is chosen ahead of time, without any divide hardware. The caller precomputes a scaled reciprocal of that divisor, C = ceil(2^(2W)/d), and presents it as two W-bit words with every dividend. The low reciprocal word enters one W-by-W product, and only the upper half of that product is kept. The high reciprocal word enters a second, full product. The two are added, and the quotient is the upper W bits of that sum. There is no post-shift and no correction that depends on the divisor.

A divisor of one has a reciprocal that does not fit in two words. For that divisor the caller raises a flag instead. The unit then passes the dividend through as the quotient, with the same latency as the multiply path. Operands enter on a valid/ready handshake. Results leave on a valid output that the consumer can hold back with a ready input. The pipeline has three register stages and accepts one operand set per cycle while the output is not stalled.

Top module: `recip_quot_unit`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0 and in_ready is 1.
- R2: For a divisor d with 2 <= d <= 2^W-1, with in_recip_hi set to the upper W bits of ceil(2^(2W)/d) and in_recip_lo set to its lower W bits, out_quotient equals floor(n/d) for every dividend n, including 0, 1 and 2^W-1.
- R3: The sum of the full high product and the upper half of the low product is formed W*2+1 bits wide. A carry out of its lower word reaches the quotient word, and the sum never sets its topmost bit.
- R4: When in_unit_divisor is 1, out_quotient equals in_dividend whatever in_recip_hi and in_recip_lo hold.
- R5: An operand set accepted at a rising edge, with out_ready held at 1, shows up on out_valid after the third rising edge counted from the accepting one.
- R6: While out_ready is 1, in_ready stays 1, so a new operand set can enter on every cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_quotient hold their values on the next cycle and in_ready is 0.
- R8: Results leave in the order the operands were accepted. Under any pattern of stalls, none is lost and none is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_dividend | input | W | Dividend n |
| in_recip_hi | input | W | Upper word of the scaled reciprocal |
| in_recip_lo | input | W | Lower word of the scaled reciprocal |
| in_unit_divisor | input | 1 | Divisor equals one: pass the dividend through |
| out_valid | output | 1 | Quotient present |
| out_ready | input | 1 | Consumer takes the quotient this cycle |
| out_quotient | output | W | Unsigned quotient |

## Verification
The bench aims first at dividends at the extremes (0, 1, 2^W-1) against divisors 2, 3, 7, 10, powers of two and 2^W-1. It checks every result against a plain integer division. A unit that dropped the carry from the low-word sum would be one too small for many of these cases, and a unit that kept the low product word or shifted the result would be off by far more. Unit-divisor operands are sent with random reciprocal words, so a unit that let those words into the bypass path would return garbage. Random stalls on out_ready test that a held result neither changes nor repeats nor goes missing. An unstalled stretch times the latency and the one-per-cycle intake, so an extra or a missing pipeline register would show.

// File: rtl/rq_mul_stage.sv
module rq_mul_stage #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic           in_fire,
  input  logic [W-1:0]   in_n,
  input  logic [W-1:0]   in_ch,
  input  logic [W-1:0]   in_cl,
  input  logic           in_one,
  output logic           s1_valid,
  output logic           s1_one,
  output logic [W-1:0]   s1_n,
  output logic [2*W-1:0] s1_prod_hi,
  output logic [W-1:0]   s1_lo_top
);
  localparam int W2 = 2 * W;

  // full 2W-bit product of dividend and high reciprocal word
  function automatic logic [W2-1:0] full_product(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  // upper word only of dividend times low reciprocal word; lower word dropped
  function automatic logic [W-1:0] upper_half(input logic [W-1:0] a, input logic [W-1:0] b);
    return W'(({{W{1'b0}}, a} * {{W{1'b0}}, b}) >> W);
  endfunction

  logic [W2-1:0] prod_hi_next;
  logic [W-1:0]  lo_top_next;

  assign prod_hi_next = full_product(in_n, in_ch);
  assign lo_top_next  = upper_half(in_n, in_cl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_one     <= 1'b0;
      s1_n       <= '0;
      s1_prod_hi <= '0;
      s1_lo_top  <= '0;
    end else if (advance) begin
      s1_valid <= in_fire;
      if (in_fire) begin
        s1_one     <= in_one;
        s1_n       <= in_n;
        s1_prod_hi <= prod_hi_next;
        s1_lo_top  <= lo_top_next;
      end
    end
  end

  // R7: a stalled pipeline keeps its first stage intact
  a_r7_s1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(s1_valid) && $stable(s1_n) && $stable(s1_prod_hi) && $stable(s1_lo_top));
endmodule

// File: rtl/rq_add_stage.sv
module rq_add_stage #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic           s1_valid,
  input  logic           s1_one,
  input  logic [W-1:0]   s1_n,
  input  logic [2*W-1:0] s1_prod_hi,
  input  logic [W-1:0]   s1_lo_top,
  output logic           s2_valid,
  output logic [W-1:0]   s2_q
);
  localparam int W2 = 2 * W;
  localparam int WS = W2 + 1;

  // wide sum with one spare bit of headroom above the 2W-bit product
  function automatic logic [WS-1:0] wide_sum(input logic [W2-1:0] ph, input logic [W-1:0] lt);
    return {1'b0, ph} + {{(W + 1){1'b0}}, lt};
  endfunction

  logic [WS-1:0] sum;
  logic [W-1:0]  q_mul;
  logic [W-1:0]  q_next;

  assign sum    = wide_sum(s1_prod_hi, s1_lo_top);
  assign q_mul  = sum[W2-1:W];
  assign q_next = s1_one ? s1_n : q_mul;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_q     <= '0;
    end else if (advance) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_q <= q_next;
    end
  end

  // R3: the spare top bit of the sum is never needed
  a_r3_headroom: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> sum < {1'b1, {W2{1'b0}}});

  // R4: unit divisor passes the dividend through
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_one && advance |=> s2_valid && s2_q == $past(s1_n));

  // R2: any reciprocal below 2^(2W) yields a quotient below the dividend
  a_r2_q_below_n: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_one && advance |=>
      (s2_q < $past(s1_n)) || ($past(s1_n) == '0 && s2_q == '0));
endmodule

// File: rtl/rq_out_stage.sv
module rq_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         out_ready,
  input  logic         s2_valid,
  input  logic [W-1:0] s2_q,
  output logic         out_valid,
  output logic [W-1:0] out_quotient
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_quotient <= '0;
    end else if (advance) begin
      out_valid <= s2_valid;
      if (s2_valid) out_quotient <= s2_q;
    end
  end

  // R6: a moving pipeline leaves no bubble behind a valid second stage
  a_r6_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid && advance |=> out_valid);

  // R7: a held result does not change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quotient));
endmodule

// File: rtl/recip_quot_unit.sv
module recip_quot_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_recip_hi,
  input  logic [W-1:0] in_recip_lo,
  input  logic         in_unit_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quotient
);
  localparam int W2 = 2 * W;

  logic           advance;
  logic           in_fire;
  logic           s1_valid;
  logic           s1_one;
  logic [W-1:0]   s1_n;
  logic [W2-1:0]  s1_prod_hi;
  logic [W-1:0]   s1_lo_top;
  logic           s2_valid;
  logic [W-1:0]   s2_q;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign in_fire  = in_valid && advance;

  rq_mul_stage #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .advance(advance), .in_fire(in_fire),
    .in_n(in_dividend), .in_ch(in_recip_hi), .in_cl(in_recip_lo), .in_one(in_unit_divisor),
    .s1_valid(s1_valid), .s1_one(s1_one), .s1_n(s1_n),
    .s1_prod_hi(s1_prod_hi), .s1_lo_top(s1_lo_top)
  );

  rq_add_stage #(.W(W)) u_add (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .s1_valid(s1_valid), .s1_one(s1_one), .s1_n(s1_n),
    .s1_prod_hi(s1_prod_hi), .s1_lo_top(s1_lo_top),
    .s2_valid(s2_valid), .s2_q(s2_q)
  );

  rq_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .advance(advance), .out_ready(out_ready),
    .s2_valid(s2_valid), .s2_q(s2_q),
    .out_valid(out_valid), .out_quotient(out_quotient)
  );

  // R7: no intake while a result is held back
  a_r7_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1: the output is empty right after reset is released
  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/recip_quot_unit_test.sv
module recip_quot_unit_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_recip_hi = '0;
  logic [W-1:0] in_recip_lo = '0;
  logic         in_unit_divisor = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_quotient;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  bit done = 0;
  bit timing_mode = 0;
  bit prev_held = 0;
  logic [W-1:0] prev_q = '0;

  int exp_q[$];
  int exp_tag[$];
  int acc_cycle[$];

  always #5 clk = ~clk;

  recip_quot_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_recip_hi(in_recip_hi), .in_recip_lo(in_recip_lo),
    .in_unit_divisor(in_unit_divisor), .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // one cycle: drive after the falling edge, then judge what the next rising edge will do
  task automatic step(input bit iv, input int n, input int d, input bit ordy);
    longint c;
    @(negedge clk);
    in_valid        = iv;
    in_dividend     = W'(n);
    out_ready       = ordy;
    in_unit_divisor = (d == 1);
    if (d == 1) begin
      in_recip_hi = W'($urandom);
      in_recip_lo = W'($urandom);
    end else begin
      c = ((64'd1 << (2 * W)) + longint'(d) - 1) / longint'(d);
      in_recip_hi = W'(c >> W);
      in_recip_lo = W'(c);
    end
    #1;
    if (prev_held) begin
      check(out_valid == 1'b1, "R7 hold valid", out_valid, 1);
      check(out_quotient == prev_q, "R7 hold value", out_quotient, prev_q);
    end
    if (timing_mode) check(in_ready == 1'b1, "R6 ready", in_ready, 1);
    if (out_valid && !out_ready) check(in_ready == 1'b0, "R7 no intake", in_ready, 0);
    prev_held = out_valid && !out_ready;
    prev_q    = out_quotient;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 extra result", out_quotient, -1);
      end else begin
        int q = exp_q.pop_front();
        int t = exp_tag.pop_front();
        int a = acc_cycle.pop_front();
        if (t == 4) check(out_quotient == W'(q), "R4 unit divisor", out_quotient, q);
        else        check(out_quotient == W'(q), "R2 quotient", out_quotient, q);
        if (timing_mode) check(cycle - a == 3, "R5 latency", cycle - a, 3);
      end
    end
    if (iv && in_ready) begin
      exp_q.push_back(n / d);
      exp_tag.push_back(d == 1 ? 4 : 2);
      acc_cycle.push_back(cycle);
    end
    cycle++;
  endtask

  initial begin
    int divs[8] = '{2, 3, 7, 10, 1024, 65535, 1, 32768};
    int ns[5]   = '{0, 1, 65535, 65534, 12345};
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    // unstalled stream: boundary dividends, timing and intake rate (R2 R3 R4 R5 R6)
    timing_mode = 1;
    foreach (divs[i]) foreach (ns[j]) step(1'b1, ns[j], divs[i], 1'b1);
    repeat (5) step(1'b0, 0, 2, 1'b1);

    // lone operand to time the latency from an empty pipe (R5)
    step(1'b1, 1000, 7, 1'b1);
    repeat (5) step(1'b0, 0, 2, 1'b1);
    timing_mode = 0;

    // random dividends and divisors under random stalls (R2 R3 R7 R8)
    for (int k = 0; k < 3000; k++) begin
      int d = ($urandom % 8 == 0) ? 1 : 2 + int'($urandom % 65534);
      step($urandom % 4 != 0, int'($urandom % 65536), d, $urandom % 3 != 0);
    end
    // carry-heavy cases: divisors near powers of two with top dividends (R3)
    for (int k = 0; k < 200; k++) begin
      int d = (k % 2 == 0) ? 3 : 65535 - (k % 17);
      step(1'b1, 65535 - (k % 40), d, $urandom % 2 == 0);
    end

    // drain (R8)
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) step(1'b0, 0, 2, 1'b1);
    check(exp_q.size() == 0, "R8 all results out", exp_q.size(), 0);
    step(1'b0, 0, 2, 1'b1);
    check(out_valid == 1'b0, "R8 no extra result", out_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule